// File: doc/BRIEF.md
# Memory Power Mode Controller

This block steers an embedded SRAM macro through four power modes. It drives three kinds of control: an enable for each group of peripheral power switches, a retention control for the bitcell array, and the array supply switch. A requester asks for a mode with a one-cycle strobe. The controller reports the settled mode and raises a busy flag for the whole of any change. Read and write requests pass through the block, and it grants them only while the macro is fully powered and no change is in progress.

Lowering the power always takes a single step. Raising it is staged so that in-rush current is spread over time. The sequence is: array supply first, then a retention settle stage, then the missing peripheral groups one at a time, lowest index first. Each wait is a parameter in cycles. Waking from shutdown therefore takes the longest.

The sequencer has five states:
- `ST_IDLE`: settled.
- `ST_DOWN`: a one-cycle power reduction.
- `ST_ARR`: array supply ramp.
- `ST_RET`: retention settle.
- `ST_GRP`: one peripheral group step.

The transitions are:
- `ST_IDLE` → `ST_DOWN` for a deeper mode.
- `ST_IDLE` → `ST_ARR` for a wake from shutdown.
- `ST_IDLE` → `ST_RET` for a wake from either sleep mode.
- `ST_ARR` → `ST_RET`.
- `ST_RET` → `ST_GRP` when groups are missing.
- `ST_GRP` → `ST_GRP` for each further missing group.
- `ST_RET` or `ST_GRP` → `ST_IDLE` when nothing is missing.
- `ST_DOWN` → `ST_IDLE`.

Top module: `mem_pwr_ctrl`

## Requirements
- R1: After reset the block reports shutdown, and it has array power off, retention off, all peripheral groups off, busy low and data_invalid high. Mode codes are 2'b00 normal, 2'b01 light sleep, 2'b10 deep sleep and 2'b11 shutdown.
- R2: Settled in normal, every peripheral group is enabled, array power is on and retention is off.
- R3: Settled in light sleep, the groups set in LITE_OFF_MASK (by default groups 2 and 3) are off and the others are on, with retention on and array power on.
- R4: Settled in deep sleep, all groups are off, retention is on and array power stays on.
- R5: Settled in shutdown, all groups, retention and array power are off. Any move to a deeper mode (a numerically higher code) shows busy for exactly one cycle.
- R6: A wake from shutdown turns array power on in its first busy cycle, waits T_ARRAY cycles, and then spends T_RET cycles in the retention stage. Every wake then enables each missing group in ascending index order, one group every T_STEP cycles. Busy length equals the sum of the stages.
- R7: Busy stays high for the entire transition, and the reported mode changes only as busy falls. A request for the mode already settled is ignored and raises no busy.
- R8: A request made while busy is held, and a later one overwrites it. The held request starts one cycle after the current transition ends.
- R9: A read or write (acc_req) is granted in the same cycle only when the mode is normal and busy is low. Otherwise it is refused and acc_err is high for the following cycle.
- R10: data_invalid is set when a move into shutdown starts. It stays set until the first granted write clears it; granted reads leave it unchanged.
- R11: No peripheral group is ever on while array power is off, and no more than one group turns on per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_vld | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode code |
| acc_req | input | 1 | Read or write attempt |
| acc_we | input | 1 | Attempt is a write |
| mode_now | output | 2 | Settled mode code |
| busy | output | 1 | Transition in progress |
| arr_pwr_en | output | 1 | Array supply switch enable |
| arr_retain | output | 1 | Array retention control |
| periph_en | output | N_PGRP | Peripheral switch group enables |
| acc_grant | output | 1 | Attempt accepted |
| acc_err | output | 1 | Attempt refused (one cycle later) |
| data_invalid | output | 1 | Array contents not trustworthy |

## Verification
A sequencer stuck in, or skipping, a stage shows up at the ports as a busy length different from the stage sum. A group that comes on too early or in the wrong order shows up as a wrong first-on sample index. Both appear within the transition where the fault occurs. A corrupted target or a lost held request leaves mode_now and the switch enables disagreeing with the R2–R5 levels on the first idle cycle. A wrong guard state shows up on the next access attempt, as a grant outside normal or a missing error pulse.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_LITE = 2'b01,
        MODE_DEEP = 2'b10,
        MODE_OFF  = 2'b11
    } pmode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DOWN,
        ST_ARR,
        ST_RET,
        ST_GRP
    } seq_t;

    function automatic logic retain_of(pmode_t m);
        return (m == MODE_LITE) || (m == MODE_DEEP);
    endfunction

endpackage

// File: rtl/mpc_wait_timer.sv
module mpc_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/mpc_access_guard.sv
module mpc_access_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic open,
    input  logic inv_set,
    input  logic acc_req,
    input  logic acc_we,
    output logic acc_grant,
    output logic acc_err,
    output logic data_inv
);

    logic err_q, inv_q;

    assign acc_grant = acc_req & open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            inv_q <= 1'b1;
        end else begin
            err_q <= acc_req & ~open;
            if (inv_set)
                inv_q <= 1'b1;
            else if (acc_grant && acc_we)
                inv_q <= 1'b0;
        end
    end

    assign acc_err  = err_q;
    assign data_inv = inv_q;

    // R10: a granted write clears the flag on the next cycle
    p_write_clears_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_grant && acc_we && !inv_set) |=> !data_inv);

    // R10: starting a shutdown always raises the flag
    p_shutdown_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_set |=> data_inv);

endmodule

// File: rtl/mem_pwr_ctrl.sv
module mem_pwr_ctrl
    import mpc_pkg::*;
#(
    parameter int              N_PGRP        = 4,
    parameter logic [N_PGRP-1:0] LITE_OFF_MASK = 4'b1100,
    parameter int              T_ARRAY       = 6,
    parameter int              T_RET         = 3,
    parameter int              T_STEP        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req_vld,
    input  logic [1:0]        mode_req,
    input  logic              acc_req,
    input  logic              acc_we,
    output logic [1:0]        mode_now,
    output logic              busy,
    output logic              arr_pwr_en,
    output logic              arr_retain,
    output logic [N_PGRP-1:0] periph_en,
    output logic              acc_grant,
    output logic              acc_err,
    output logic              data_invalid
);

    localparam int T_MAX0 = (T_ARRAY > T_RET) ? T_ARRAY : T_RET;
    localparam int T_MAX  = (T_MAX0 > T_STEP) ? T_MAX0 : T_STEP;
    localparam int TW     = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] LD_ARR  = TW'(T_ARRAY - 1);
    localparam logic [TW-1:0] LD_RET  = TW'(T_RET - 1);
    localparam logic [TW-1:0] LD_STEP = TW'(T_STEP - 1);

    initial begin
        if (T_ARRAY < 1 || T_RET < 1 || T_STEP < 1)
            $error("mem_pwr_ctrl: every wait must be at least one cycle");
    end

    function automatic logic [N_PGRP-1:0] grp_goal(pmode_t m);
        unique case (m)
            MODE_RUN:  return '1;
            MODE_LITE: return ~LITE_OFF_MASK;
            default:   return '0;
        endcase
    endfunction

    seq_t              st_q, st_n;
    pmode_t            cur_q, cur_n, tgt_q, tgt_n, pm_q, pm_n, goal;
    logic              pv_q, pv_n, go;
    logic              arr_q, arr_n, ret_q, ret_n;
    logic [N_PGRP-1:0] grp_q, grp_n, missing, first_bit;
    logic              t_load, t_done, inv_set, gate_open;
    logic [TW-1:0]     t_val;

    mpc_wait_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    assign missing   = grp_goal(tgt_q) & ~grp_q;
    assign first_bit = missing & (~missing + 1'b1);

    // next-state and sequencing decisions
    always_comb begin
        st_n    = st_q;
        cur_n   = cur_q;
        tgt_n   = tgt_q;
        pv_n    = pv_q;
        pm_n    = pm_q;
        arr_n   = arr_q;
        ret_n   = ret_q;
        grp_n   = grp_q;
        t_load  = 1'b0;
        t_val   = '0;
        inv_set = 1'b0;
        go      = 1'b0;
        goal    = cur_q;
        unique case (st_q)
            ST_IDLE: begin
                if (mode_req_vld) begin
                    go   = 1'b1;
                    goal = pmode_t'(mode_req);
                    pv_n = 1'b0;
                end else if (pv_q) begin
                    go   = 1'b1;
                    goal = pm_q;
                    pv_n = 1'b0;
                end
                if (go && goal != cur_q) begin
                    tgt_n = goal;
                    if (goal > cur_q) begin
                        st_n    = ST_DOWN;
                        grp_n   = grp_q & grp_goal(goal);
                        ret_n   = retain_of(goal);
                        arr_n   = (goal != MODE_OFF);
                        inv_set = (goal == MODE_OFF);
                    end else if (cur_q == MODE_OFF) begin
                        st_n   = ST_ARR;
                        arr_n  = 1'b1;
                        t_load = 1'b1;
                        t_val  = LD_ARR;
                    end else begin
                        st_n   = ST_RET;
                        ret_n  = retain_of(goal);
                        t_load = 1'b1;
                        t_val  = LD_RET;
                    end
                end
            end
            ST_DOWN: begin
                st_n  = ST_IDLE;
                cur_n = tgt_q;
            end
            ST_ARR: begin
                if (t_done) begin
                    st_n   = ST_RET;
                    ret_n  = retain_of(tgt_q);
                    t_load = 1'b1;
                    t_val  = LD_RET;
                end
            end
            ST_RET, ST_GRP: begin
                if (t_done) begin
                    if (missing != '0) begin
                        st_n   = ST_GRP;
                        grp_n  = grp_q | first_bit;
                        t_load = 1'b1;
                        t_val  = LD_STEP;
                    end else begin
                        st_n  = ST_IDLE;
                        cur_n = tgt_q;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (st_q != ST_IDLE && mode_req_vld) begin
            pv_n = 1'b1;
            pm_n = pmode_t'(mode_req);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cur_q <= MODE_OFF;
            tgt_q <= MODE_OFF;
            pv_q  <= 1'b0;
            pm_q  <= MODE_OFF;
            arr_q <= 1'b0;
            ret_q <= 1'b0;
            grp_q <= '0;
        end else begin
            st_q  <= st_n;
            cur_q <= cur_n;
            tgt_q <= tgt_n;
            pv_q  <= pv_n;
            pm_q  <= pm_n;
            arr_q <= arr_n;
            ret_q <= ret_n;
            grp_q <= grp_n;
        end
    end

    // outputs
    always_comb begin
        mode_now   = cur_q;
        busy       = (st_q != ST_IDLE);
        arr_pwr_en = arr_q;
        arr_retain = ret_q;
        periph_en  = grp_q;
        gate_open  = (cur_q == MODE_RUN) && (st_q == ST_IDLE);
    end

    mpc_access_guard i_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .open      (gate_open),
        .inv_set   (inv_set),
        .acc_req   (acc_req),
        .acc_we    (acc_we),
        .acc_grant (acc_grant),
        .acc_err   (acc_err),
        .data_inv  (data_invalid)
    );

    // R2: settled normal means full power
    p_run_full_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cur_q == MODE_RUN) |-> (grp_q == '1 && arr_q && !ret_q));

    // R3: settled light sleep levels
    p_lite_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cur_q == MODE_LITE) |-> (grp_q == ~LITE_OFF_MASK && arr_q && ret_q));

    // R4: settled deep sleep levels
    p_deep_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cur_q == MODE_DEEP) |-> (grp_q == '0 && arr_q && ret_q));

    // R5: without array supply nothing else is driven
    p_dark_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_q |-> (!ret_q && grp_q == '0));

    // R6: at most one group turns on per cycle
    p_one_group_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grp_q & ~$past(grp_q)) <= 1);

    // R7: reported mode moves only at the end of a transition
    p_mode_moves_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> ($past(st_q) != ST_IDLE && st_q == ST_IDLE));

    // R9: grants only in settled normal
    p_grant_only_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> (mode_now == 2'b00 && !busy));

    // R11: groups need the array supply
    p_group_needs_array_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_en) |-> arr_pwr_en);

endmodule

// File: tb/test_mem_pwr_ctrl.sv
module test_mem_pwr_ctrl;

    localparam int N   = 4;
    localparam logic [N-1:0] LOFF = 4'b1100;
    localparam int TA  = 6;
    localparam int TR  = 3;
    localparam int TS  = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_req_vld = 1'b0;
    logic [1:0]   mode_req = 2'b00;
    logic         acc_req = 1'b0;
    logic         acc_we = 1'b0;
    logic [1:0]   mode_now;
    logic         busy, arr_pwr_en, arr_retain, acc_grant, acc_err, data_invalid;
    logic [N-1:0] periph_en;

    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;
    logic [N-1:0] prev_en = '0;
    bit done = 0;

    always #10 clk = ~clk;

    mem_pwr_ctrl #(.N_PGRP(N), .LITE_OFF_MASK(LOFF), .T_ARRAY(TA), .T_RET(TR), .T_STEP(TS)) i_mem_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
        .acc_req(acc_req), .acc_we(acc_we), .mode_now(mode_now), .busy(busy),
        .arr_pwr_en(arr_pwr_en), .arr_retain(arr_retain), .periph_en(periph_en),
        .acc_grant(acc_grant), .acc_err(acc_err), .data_invalid(data_invalid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] goal_en(input logic [1:0] m);
        case (m)
            2'b00:   return '1;
            2'b01:   return ~LOFF;
            default: return '0;
        endcase
    endfunction

    function automatic int exp_busy(input logic [1:0] from, input logic [1:0] to);
        if (to > from) return 1;
        return ((from == 2'b11) ? TA : 0) + TR + TS * $countones(goal_en(to) & ~goal_en(from));
    endfunction

    // R2..R5 settled levels
    task automatic check_levels(input logic [1:0] m, input string req);
        chk(mode_now == m, {req, " mode"}, mode_now, m);
        chk(periph_en == goal_en(m), {req, " groups"}, periph_en, goal_en(m));
        chk(arr_retain == (m == 2'b01 || m == 2'b10), {req, " retention"}, arr_retain, (m == 2'b01 || m == 2'b10));
        chk(arr_pwr_en == (m != 2'b11), {req, " array power"}, arr_pwr_en, (m != 2'b11));
    endtask

    // R6/R7: request a mode, count busy samples, check group order
    task automatic do_mode(input logic [1:0] to, input string req);
        logic [1:0] from;
        int first_on [N];
        int n;
        int base;
        int j;
        from = mode_now;
        for (int k = 0; k < N; k++) first_on[k] = periph_en[k] ? -2 : -1;
        @(negedge clk);
        mode_req_vld = 1'b1;
        mode_req = to;
        @(negedge clk);
        mode_req_vld = 1'b0;
        n = 0;
        if (from == 2'b11 && to < from)
            chk(busy && arr_pwr_en && periph_en == '0, "R6 array first", periph_en, 0);
        while (busy && n < 1000) begin
            for (int k = 0; k < N; k++)
                if (periph_en[k] && first_on[k] == -1) first_on[k] = n;
            n++;
            @(negedge clk);
        end
        chk(n == ((to == from) ? 0 : exp_busy(from, to)), "R7 busy length", n, exp_busy(from, to));
        if (to < from) begin
            base = ((from == 2'b11) ? TA : 0) + TR;
            j = 0;
            for (int k = 0; k < N; k++) begin
                if (first_on[k] != -2 && goal_en(to)[k]) begin
                    chk(first_on[k] == base + j * TS, "R6 group step", first_on[k], base + j * TS);
                    j++;
                end
            end
        end
        check_levels(to, req);
    endtask

    task automatic t_reset;
        chk(mode_now == 2'b11, "R1 reset mode", mode_now, 3);
        chk(!busy && !arr_pwr_en && !arr_retain && periph_en == '0, "R1 reset switches", periph_en, 0);
        chk(data_invalid, "R1 reset data_invalid", data_invalid, 1);
    endtask

    task automatic t_same_ignored;
        @(negedge clk);
        mode_req_vld = 1'b1;
        mode_req = mode_now;
        @(negedge clk);
        mode_req_vld = 1'b0;
        chk(!busy, "R7 same-mode request ignored", busy, 0);
    endtask

    task automatic access(input bit we, input bit exp_grant, input string req);
        @(negedge clk);
        acc_req = 1'b1;
        acc_we = we;
        #1;
        chk(acc_grant == exp_grant, {req, " grant"}, acc_grant, exp_grant);
        @(negedge clk);
        acc_req = 1'b0;
        chk(acc_err == !exp_grant, {req, " error pulse"}, acc_err, !exp_grant);
        @(negedge clk);
        chk(!acc_err, {req, " error one cycle"}, acc_err, 0);
    endtask

    task automatic t_queue;
        int n;
        @(negedge clk);
        mode_req_vld = 1'b1;
        mode_req = 2'b00;
        @(negedge clk);
        mode_req = 2'b11;
        @(negedge clk);
        mode_req = 2'b01;
        @(negedge clk);
        mode_req_vld = 1'b0;
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(mode_now == 2'b00, "R8 first transition completes", mode_now, 0);
        @(negedge clk);
        chk(busy, "R8 held request starts", busy, 1);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(n == 1, "R8 held request length", n, 1);
        check_levels(2'b01, "R8 last request wins");
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // R11 monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if ((|periph_en) && !arr_pwr_en) viol++;
            if ($countones(periph_en & ~prev_en) > 1) viol++;
            prev_en = periph_en;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        do_mode(2'b00, "R2 wake from shutdown");
        t_same_ignored();
        access(1'b0, 1'b1, "R9 read in normal");
        chk(data_invalid, "R10 read keeps flag", data_invalid, 1);
        access(1'b1, 1'b1, "R9 write in normal");
        chk(!data_invalid, "R10 write clears flag", data_invalid, 0);
        do_mode(2'b01, "R3 normal to light");
        access(1'b0, 1'b0, "R9 read in light");
        do_mode(2'b10, "R4 light to deep");
        access(1'b1, 1'b0, "R9 write in deep");
        do_mode(2'b01, "R3 deep to light");
        do_mode(2'b00, "R2 light to normal");
        do_mode(2'b11, "R5 normal to shutdown");
        chk(data_invalid, "R10 shutdown sets flag", data_invalid, 1);
        do_mode(2'b10, "R4 shutdown to deep");
        chk(data_invalid, "R10 flag kept after shutdown", data_invalid, 1);
        t_queue();
        do_mode(2'b11, "R5 light to shutdown");
        do_mode(2'b01, "R3 shutdown to light");
        do_mode(2'b00, "R2 light to normal again");
        chk(viol == 0, "R11 group vs array and step rule", viol, 0);
        done = 1;
        report();
    end

endmodule